// File: doc/BRIEF.md
# Serial Transmitter with Programmable Bit Rate and Break

This block is the transmit half of an asynchronous serial port. The system clock is divided in two stages to make an enable at sixteen times the bit rate. The first stage is a prescaler with four fixed ratios. The second stage divides by a power of two. Each bit on the line lasts sixteen of these enables.

Software places a character in a one-entry holding register. The character moves into a shift register when the line is free. It goes out as a low start bit, eight or nine data bits with the least significant bit first, and a high stop bit.

Two flags report progress. One says the holding register is free again. The other says the line has gone quiet after the last stop bit. Each flag has its own interrupt enable. A break control makes the transmitter send frames that are low for every bit, for as long as the control is set.

Top module: `uart_tx_core`

## Requirements
- R1: The time for one bit is 16·P·2^S system clocks. P is taken from `baud_cfg[5:4]` (00→1, 01→3, 10→4, 11→13) and S is `baud_cfg[2:0]`. A frame of N bits therefore lasts exactly N·16·P·2^S clocks.
- R2: With `fmt_nine`=0, a frame is 10 bits long: a 0 start bit, then `wr_data[0]` through `wr_data[7]`, then a 1 stop bit.
- R3: With `fmt_nine`=1, a frame is 11 bits long. The ninth data bit, sent just before the stop bit, is the value of `tx_bit8`.
- R4: `tdre` is 1 after reset. A write (`wr_en`=1) clears it in the next cycle. It returns to 1 on the same clock edge at which the start bit of that character appears on `txd`.
- R5: `tc` is 1 after reset and a write clears it. It becomes 1 exactly one frame time after the start bit appears, provided no further character is waiting at that moment.
- R6: A character written while a frame is in progress starts immediately after the stop bit of that frame, with no idle time between them. `tc` stays 0 across the boundary between the two frames.
- R7: `irq` = (`ctrl[7]` AND `tdre`) OR (`ctrl[6]` AND `tc`). `ctrl[7]` enables the holding-register-free interrupt and `ctrl[6]` enables the line-quiet interrupt.
- R8: While `ctrl[0]` is 1, whole frames of all-zero bits are sent, one after another. The holding register and `tdre` are left untouched. After `ctrl[0]` is cleared, the current break frame finishes and the line goes high at the frame boundary.
- R9: While `ctrl[3]` (transmit enable) is 0, `txd` is held high and no frame starts. A waiting character is kept and is sent once `ctrl[3]` becomes 1.
- R10: After reset, `txd` is 1, `tdre` is 1 and `tc` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| baud_cfg | input | 8 | Bit-rate setting: prescale code in [5:4], power-of-two code in [2:0] |
| ctrl | input | 8 | [7] holding-free interrupt enable, [6] line-quiet interrupt enable, [3] transmit enable, [0] break |
| fmt_nine | input | 1 | 1 selects nine data bits |
| tx_bit8 | input | 1 | Ninth data bit |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | 8 | Character to send |
| txd | output | 1 | Serial line, idles high |
| tdre | output | 1 | Holding register is free |
| tc | output | 1 | Line is quiet after the last frame |
| irq | output | 1 | Interrupt request |

## Verification
Let T = P·2^S. Every frame is timed from the falling edge of its start bit, which the bench sees one clock after the edge where it is registered. Bit k is sampled at 16·k·T + 8·T clocks after that edge, which is the middle of the bit. `tc` is checked to be 0 one clock before N·16·T and 1 exactly at N·16·T. `tdre` is checked at the first low sample of the start bit, and again one cycle after a write. The break length is counted to the exact cycle.

// File: rtl/uart_tx_pkg.sv
// Shared constants and the fixed prescale decode of the serial transmitter.
// Assumes the prescale code is two bits wide.
package uart_tx_pkg;
    localparam int PRE_W = 4;   // wide enough for the largest prescale ratio minus one

    // Maps a prescale code to its divide ratio.
    function automatic int prescale_div(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 3;
            2'd2:    return 4;
            default: return 13;
        endcase
    endfunction
endpackage

// File: rtl/uart_tx_baud.sv
// Bit-rate enable generator: a prescaler followed by a power-of-two divider.
// It produces a one-cycle pulse at sixteen times the bit rate.
// Assumes the configuration changes only while the line is idle. Counters
// that are beyond a new, smaller limit wrap at once.
module uart_tx_baud
    import uart_tx_pkg::*;
#(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       pre_code,
    input  logic [SEL_W-1:0] sel_code,
    output logic             tick16
);
    localparam int SELC_W = (1 << SEL_W) - 1;

    logic [PRE_W-1:0]  pre_cnt;
    logic [PRE_W-1:0]  pre_lim;
    logic [SELC_W-1:0] sel_cnt;
    logic [SELC_W-1:0] sel_lim;
    logic              pre_hit;
    logic              sel_hit;

    // Decode the terminal counts for both stages.
    always_comb begin
        pre_lim = PRE_W'(prescale_div(pre_code) - 1);
        sel_lim = ~({SELC_W{1'b1}} << sel_code);
        pre_hit = (pre_cnt >= pre_lim);
        sel_hit = (sel_cnt >= sel_lim);
    end

    // First stage: the prescale counter.
    always_ff @(posedge clk) begin
        if (!rst_n)       pre_cnt <= '0;
        else if (pre_hit) pre_cnt <= '0;
        else              pre_cnt <= pre_cnt + 1'b1;
    end

    // Second stage: counts prescaler terminal counts.
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_cnt <= '0;
        else if (pre_hit) sel_cnt <= sel_hit ? '0 : sel_cnt + 1'b1;
    end

    assign tick16 = pre_hit && sel_hit;

    // Unless the total ratio is 1, two enables never fall in adjacent cycles
    // while the configuration is steady.
    assert_tick_gap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick16 && (pre_lim != '0 || sel_lim != '0)) |=>
        (!tick16 || !$stable(pre_code) || !$stable(sel_code)));
endmodule

// File: rtl/uart_tx_frame.sv
// Frame engine: it counts sixteen enables per bit and shifts out start bit,
// data bits and stop bit, or all-zero break frames.
// Frames start only on an enable. A frame may follow the previous stop bit
// with no gap. Clearing the enable aborts the current frame and forces the
// line high.
module uart_tx_frame #(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick16,
    input  logic              te,
    input  logic              sbk,
    input  logic              nine,
    input  logic              bit8,
    input  logic              pending,
    input  logic [DATA_W-1:0] data,
    output logic              txd,
    output logic              take,
    output logic              done
);
    localparam int FRM_W = DATA_W + 3;
    localparam int SUB_W = $clog2(OS_RATE);
    localparam int IDX_W = $clog2(FRM_W);

    logic             busy;
    logic             brk;
    logic [FRM_W-1:0] sh;
    logic [IDX_W-1:0] idx;
    logic [SUB_W-1:0] sub;
    logic             last_sub;
    logic             last_bit;
    logic             frame_end;
    logic             may_start;
    logic [FRM_W-1:0] new_frame;

    // Decode the bit boundaries, the start condition and the next frame image.
    always_comb begin
        last_sub  = (sub == SUB_W'(OS_RATE - 1));
        last_bit  = (idx == (nine ? IDX_W'(FRM_W - 1) : IDX_W'(FRM_W - 2)));
        frame_end = busy && tick16 && last_sub && last_bit;
        may_start = te && tick16 && (!busy || frame_end) && (sbk || pending);
        new_frame = sbk ? '0 : {1'b1, (nine ? bit8 : 1'b1), data, 1'b0};
    end

    // Sequence the frame. The line is always the low bit of the shifter.
    always_ff @(posedge clk) begin
        if (!rst_n || !te) begin
            busy <= 1'b0;
            brk  <= 1'b0;
            sh   <= '1;
            idx  <= '0;
            sub  <= '0;
        end else if (may_start) begin
            busy <= 1'b1;
            brk  <= sbk;
            sh   <= new_frame;
            idx  <= '0;
            sub  <= '0;
        end else if (frame_end) begin
            busy <= 1'b0;
            brk  <= 1'b0;
            sh   <= '1;
            idx  <= '0;
            sub  <= '0;
        end else if (busy && tick16) begin
            sub <= last_sub ? '0 : sub + 1'b1;
            if (last_sub) begin
                idx <= idx + 1'b1;
                sh  <= {1'b1, sh[FRM_W-1:1]};
            end
        end
    end

    assign txd  = sh[0];
    assign take = may_start && !sbk;
    assign done = frame_end && !may_start;

    assert_te_off_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !te |=> txd);
    assert_break_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && brk) |-> !txd);
    assert_take_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (busy && !txd));
    assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!busy && txd));
endmodule

// File: rtl/uart_tx_core.sv
// Serial transmitter top: the holding register, the two status flags and the
// interrupt request, joined to the bit-rate generator and the frame engine.
// A write always wins over a flag set in the same cycle. A write that hits a
// full holding register replaces the character in it.
module uart_tx_core #(
    parameter int DATA_W  = 8,
    parameter int OS_RATE = 16,
    parameter int SEL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        baud_cfg,
    input  logic [7:0]        ctrl,
    input  logic              fmt_nine,
    input  logic              tx_bit8,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              txd,
    output logic              tdre,
    output logic              tc,
    output logic              irq
);
    logic              tick16;
    logic              take;
    logic              done;
    logic [DATA_W-1:0] hold_q;
    logic              tdre_q;
    logic              tc_q;
    logic              unused_bits;

    assign unused_bits = ^{ctrl[5:4], ctrl[2:1], baud_cfg[7:6], baud_cfg[3]};

    uart_tx_baud #(.SEL_W(SEL_W)) u_baud (
        .clk      (clk),
        .rst_n    (rst_n),
        .pre_code (baud_cfg[5:4]),
        .sel_code (baud_cfg[SEL_W-1:0]),
        .tick16   (tick16)
    );

    uart_tx_frame #(.DATA_W(DATA_W), .OS_RATE(OS_RATE)) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick16  (tick16),
        .te      (ctrl[3]),
        .sbk     (ctrl[0]),
        .nine    (fmt_nine),
        .bit8    (tx_bit8),
        .pending (!tdre_q),
        .data    (hold_q),
        .txd     (txd),
        .take    (take),
        .done    (done)
    );

    // Holding register and the two flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
            tdre_q <= 1'b1;
            tc_q   <= 1'b1;
        end else begin
            if (wr_en) hold_q <= wr_data;
            if (wr_en)     tdre_q <= 1'b0;
            else if (take) tdre_q <= 1'b1;
            if (wr_en)     tc_q <= 1'b0;
            else if (done) tc_q <= 1'b1;
        end
    end

    assign tdre = tdre_q;
    assign tc   = tc_q;
    assign irq  = (ctrl[7] && tdre_q) || (ctrl[6] && tc_q);

    assert_write_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (!tdre && !tc));
    assert_take_frees_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_en) |=> tdre);
    assert_done_sets_tc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !wr_en) |=> tc);
endmodule

// File: tb/test_uart_tx_core.sv
// Self-checking bench for the serial transmitter. Every frame is timed from
// the first low sample of its start bit.
module test_uart_tx_core;
    logic       clk      = 1'b0;
    logic       rst_n    = 1'b0;
    logic [7:0] baud_cfg = 8'h00;
    logic [7:0] ctrl     = 8'h00;
    logic       fmt_nine = 1'b0;
    logic       tx_bit8  = 1'b0;
    logic       wr_en    = 1'b0;
    logic [7:0] wr_data  = 8'h00;
    logic       txd, tdre, tc, irq;

    int n_cmp   = 0;
    int n_bad   = 0;
    int elapsed = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    uart_tx_core i_uart_tx_core (
        .clk(clk), .rst_n(rst_n), .baud_cfg(baud_cfg), .ctrl(ctrl),
        .fmt_nine(fmt_nine), .tx_bit8(tx_bit8), .wr_en(wr_en), .wr_data(wr_data),
        .txd(txd), .tdre(tdre), .tc(tc), .irq(irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int pdiv(input int code);
        case (code)
            0:       return 1;
            1:       return 3;
            2:       return 4;
            default: return 13;
        endcase
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_until(input int t);
        while (elapsed < t) begin
            @(negedge clk);
            elapsed++;
        end
    endtask

    task automatic write_byte(input logic [7:0] d);
        wr_data = d;
        wr_en   = 1'b1;
        @(negedge clk);
        elapsed++;
        wr_en   = 1'b0;
    endtask

    task automatic wait_start(input string tag, input int limit, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (txd == 1'b0) begin
                seen = 1'b1;
                break;
            end
        end
        elapsed = 0;
        if (!seen) check(tag, 1, 0);
    endtask

    // Sample every bit of one frame at its middle, counting from base.
    task automatic check_bits(input string tag, input int base, input int t,
                              input bit nine, input bit t8, input logic [7:0] d);
        int nb;
        nb = nine ? 11 : 10;
        for (int k = 0; k < nb; k++) begin
            int expv;
            wait_until(base + (16 * k + 8) * t);
            if (k == 0)                expv = 0;
            else if (k <= 8)           expv = int'(d[k-1]);
            else if (k == 9 && nine)   expv = int'(t8);
            else                       expv = 1;
            check($sformatf("%s bit %0d", tag, k), int'(txd), expv);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual 0 expected 1 (run finished)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        bit seen;
        int t, f, hi_bad;
        logic [7:0] d;

        tick(4);
        rst_n = 1'b1;
        tick(1);
        check("R10 txd after reset", int'(txd), 1);
        check("R10 tdre after reset", int'(tdre), 1);
        check("R10 tc after reset", int'(tc), 1);
        check("R7 irq with enables off", int'(irq), 0);
        ctrl = 8'hC0;
        #1;
        check("R7 irq with both enables", int'(irq), 1);

        // Sweep of prescale and power-of-two codes with both frame lengths.
        ctrl = 8'h08;
        for (int pc = 0; pc < 4; pc++) begin
            for (int sc = 0; sc < 3; sc++) begin
                bit nine, t8;
                int nb;
                t    = pdiv(pc) * (1 << sc);
                nine = ((pc + sc) % 2) == 1;
                t8   = (sc % 2) == 0;
                d    = 8'((8'h35 + pc * 37 + sc * 91) % 256);
                baud_cfg = 8'(pc * 16 + sc);
                fmt_nine = nine;
                tx_bit8  = t8;
                tick(2);
                write_byte(d);
                check("R4 write clears tdre", int'(tdre), 0);
                check("R5 write clears tc", int'(tc), 0);
                wait_start("R1 start bit never appeared", 2 * t + 20, seen);
                if (seen) begin
                    nb = nine ? 11 : 10;
                    check("R4 tdre at start bit", int'(tdre), 1);
                    check_bits(nine ? "R3 nine-bit frame" : "R2 eight-bit frame",
                               0, t, nine, t8, d);
                    wait_until(nb * 16 * t - 1);
                    check("R1 tc one cycle before frame end", int'(tc), 0);
                    wait_until(nb * 16 * t);
                    check("R5 tc at frame end", int'(tc), 1);
                end
            end
        end

        // Two characters sent back to back.
        baud_cfg = 8'h30;
        fmt_nine = 1'b0;
        t = 13;
        f = 160 * t;
        tick(2);
        write_byte(8'hC3);
        wait_start("R6 first frame never started", 2 * t + 20, seen);
        if (seen) begin
            wait_until(10);
            write_byte(8'h3C);
            check_bits("R6 first frame", 0, t, 1'b0, 1'b0, 8'hC3);
            wait_until(f);
            check("R6 tc between frames", int'(tc), 0);
            check_bits("R6 second frame", f, t, 1'b0, 1'b0, 8'h3C);
            wait_until(2 * f);
            check("R6 tc after second frame", int'(tc), 1);
        end

        // Transmit disabled with a character waiting, then enabled.
        ctrl = 8'h80;
        tick(2);
        write_byte(8'h5A);
        #1;
        check("R7 irq with tdre and tc low", int'(irq), 0);
        hi_bad = 0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) hi_bad++;
        end
        check("R9 low samples while disabled", hi_bad, 0);
        check("R9 character still waiting", int'(tdre), 0);
        ctrl = 8'h88;
        wait_start("R9 waiting character not sent", 2 * t + 20, seen);
        if (seen) begin
            check("R7 irq from tdre", int'(irq), 1);
            ctrl = 8'h48;
            #1;
            check("R7 irq with tc enable only and tc low", int'(irq), 0);
            check_bits("R9 sent after enable", 0, t, 1'b0, 1'b0, 8'h5A);
            wait_until(f);
            check("R7 irq from tc", int'(irq), 1);
        end

        // Break held for one and a half frames.
        ctrl = 8'h09;
        wait_start("R8 break never started", 2 * t + 20, seen);
        if (seen) begin
            wait_until(f + f / 2);
            check("R8 tdre untouched by break", int'(tdre), 1);
            ctrl = 8'h08;
            while (txd == 1'b0 && elapsed < 4 * f) begin
                @(negedge clk);
                elapsed++;
            end
            check("R8 break length in cycles", elapsed, 2 * f);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule